// File: doc/BRIEF.md
# Destination Address Match Filter

This block decides whether an incoming frame is for this station by looking only at its 48-bit destination address. A small associative table of sixteen 48-bit station addresses is qualified by a per-entry enable mask. Three receive mode bits widen the match: promiscuous unicast, every multicast, and the all-ones broadcast address. Each presented address produces one registered verdict, which is an accept bit plus a multicast flag and a broadcast flag.

The table is not written directly by the host. The host sets a descriptor pointer and a descriptor count, then issues a load command. A load engine then walks the descriptor list in memory through a single-word read port. It fills the table from entry 0 upward and finally fetches the enable mask. For diagnostics the host can read any table entry back through the register port, but only while the block is in its reset mode.

Address bytes use wire order. Bits [7:0] of `da` are the first byte received, so bit 0 of `da` is the group (multicast) bit. Bits [47:40] are the sixth byte.

Top module: `addr_match_filter`

## Requirements
- R1: When promiscuous mode (mode register bit 0) is set and `da[0]` is 0, the frame is accepted with both flags clear. This test takes priority over every other test.
- R2: Failing R1, when all-multicast mode (mode bit 1) is set and `da[0]` is 1, the frame is accepted with the multicast flag set and the broadcast flag clear.
- R3: Failing R1 and R2, when broadcast mode (mode bit 2) is set and `da` is all ones, the frame is accepted with only the broadcast flag set. The two flags are never set together.
- R4: Otherwise the frame is accepted, with no flags, only when `da` equals a table entry whose enable-mask bit is set. If no such entry exists, the frame is rejected and all three verdict bits are 0.
- R5: `res_valid` is high in exactly the cycle after a cycle with `da_valid` high. The verdict is taken from the mode and table state at that `da_valid` cycle.
- R6: Writing command register (address 0) with bit 9 set starts a load. While the 5-bit descriptor count (address 4) is nonzero, the engine reads words ptr+1, ptr+2 and ptr+3. It stores them as entry bytes 0..5, each word low byte first, so the entry is {w3,w2,w1}. It then decrements the count and adds 4 to the descriptor pointer (address 3).
- R7: After the last descriptor, word ptr+0 of the next descriptor is loaded as the 16-bit enable mask. The mask is readable at address 9, and bit i enables entry i.
- R8: When a load completes, command bit 9, which reads as load-busy, clears and status bit 12 (address 2) is set. Writing 1 to status bit 12 clears it.
- R9: Every load command writes entries starting from index 0. Entries beyond the loaded count keep their contents.
- R10: Addresses 6, 7 and 8 return words w1, w2 and w3 of the entry selected by the low 4 bits of address 5, but only while reset mode (command bit 7, set by reset) is 1. Otherwise they read as 0.
- R11: The memory read strobe is asserted only while a load is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Register write strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data (combinational on host_addr) |
| mem_rd_en | output | 1 | Memory word read request |
| mem_addr | output | MEM_AW | Memory word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data word |
| da_valid | input | 1 | Destination address present |
| da | input | 48 | Destination address, byte 0 in bits [7:0] |
| res_valid | output | 1 | Verdict valid |
| res_accept | output | 1 | Frame accepted |
| res_mcast | output | 1 | Accepted as multicast |
| res_bcast | output | 1 | Accepted as broadcast |

## Verification
The assertions check the following on every cycle:
- the one-cycle verdict timing;
- that a flag never appears without accept, and that the two flags never appear together;
- the promiscuous and all-multicast priority outcomes;
- that readback data is zero outside reset mode;
- that memory reads occur only during a load, and that the done bit is set as the load ends.

Some behaviours can only be shown by the bench's scenarios, because each depends on a specific memory image and load sequence:
- the byte order of table entries;
- the pointer and count after a load;
- which mask word is fetched;
- the restart of the entry index at 0 on a second, shorter load;
- exact-match acceptance against enabled and disabled entries.

// File: rtl/afm_pkg.sv
package afm_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned DA_W   = 48;

    // host register addresses
    localparam logic [3:0] RA_CMD   = 4'd0;
    localparam logic [3:0] RA_MODE  = 4'd1;
    localparam logic [3:0] RA_STAT  = 4'd2;
    localparam logic [3:0] RA_DPTR  = 4'd3;
    localparam logic [3:0] RA_DCNT  = 4'd4;
    localparam logic [3:0] RA_ESEL  = 4'd5;
    localparam logic [3:0] RA_RB0   = 4'd6;
    localparam logic [3:0] RA_RB1   = 4'd7;
    localparam logic [3:0] RA_RB2   = 4'd8;
    localparam logic [3:0] RA_EMASK = 4'd9;

    localparam int unsigned CMD_LOAD_BIT  = 9;
    localparam int unsigned CMD_RMODE_BIT = 7;
    localparam int unsigned STAT_DONE_BIT = 12;

    typedef struct packed {
        logic bcast;   // bit 2
        logic allmc;   // bit 1
        logic prom;    // bit 0
    } mode_t;

    typedef struct packed {
        logic accept;
        logic mcast;
        logic bcast;
    } verdict_t;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_CHECK,
        LD_REQ,
        LD_WAIT
    } ld_state_e;

    // fixed-priority accept decision
    function automatic verdict_t judge(mode_t m, logic [DA_W-1:0] addr, logic hit);
        verdict_t v;
        v = '0;
        if (m.prom && !addr[0]) begin
            v.accept = 1'b1;
        end else if (m.allmc && addr[0]) begin
            v.accept = 1'b1;
            v.mcast  = 1'b1;
        end else if (m.bcast && (&addr)) begin
            v.accept = 1'b1;
            v.bcast  = 1'b1;
        end else if (hit) begin
            v.accept = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/afm_cam_loader.sv
module afm_cam_loader
    import afm_pkg::*;
#(
    parameter int unsigned MEM_AW = 16,
    parameter int unsigned CNT_W  = 5,
    parameter int unsigned IDX_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                ptr_we,
    input  logic                cnt_we,
    input  logic [WORD_W-1:0]   wdata,
    output logic                busy,
    output logic                done_pulse,
    output logic [MEM_AW-1:0]   ptr_q,
    output logic [CNT_W-1:0]    cnt_q,
    output logic                mem_rd_en,
    output logic [MEM_AW-1:0]   mem_addr,
    input  logic                mem_rvalid,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                ent_we,
    output logic [IDX_W-1:0]    ent_idx,
    output logic [DA_W-1:0]     ent_data,
    output logic                mask_we,
    output logic [WORD_W-1:0]   mask_data
);

    localparam int unsigned DESC_WORDS = 4;

    ld_state_e          state_q;
    logic [1:0]         widx_q;
    logic [IDX_W-1:0]   idx_q;
    logic [WORD_W-1:0]  w_lo_q;
    logic [WORD_W-1:0]  w_mid_q;
    logic               word_in;

    assign busy      = (state_q != LD_IDLE);
    assign mem_rd_en = (state_q == LD_REQ);
    assign mem_addr  = ptr_q + MEM_AW'(widx_q);
    assign word_in   = (state_q == LD_WAIT) && mem_rvalid;

    assign ent_we     = word_in && (widx_q == 2'd3);
    assign ent_idx    = idx_q;
    assign ent_data   = {mem_rdata, w_mid_q, w_lo_q};
    assign mask_we    = word_in && (widx_q == 2'd0);
    assign mask_data  = mem_rdata;
    assign done_pulse = mask_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LD_IDLE;
            widx_q  <= '0;
            idx_q   <= '0;
            w_lo_q  <= '0;
            w_mid_q <= '0;
            ptr_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                LD_IDLE: begin
                    if (ptr_we) ptr_q <= MEM_AW'(wdata);
                    if (cnt_we) cnt_q <= wdata[CNT_W-1:0];
                    if (start) begin
                        idx_q   <= '0;
                        state_q <= LD_CHECK;
                    end
                end
                LD_CHECK: begin
                    widx_q  <= (cnt_q != '0) ? 2'd1 : 2'd0;
                    state_q <= LD_REQ;
                end
                LD_REQ: begin
                    state_q <= LD_WAIT;
                end
                LD_WAIT: begin
                    if (mem_rvalid) begin
                        case (widx_q)
                            2'd0: state_q <= LD_IDLE;
                            2'd1: begin
                                w_lo_q  <= mem_rdata;
                                widx_q  <= 2'd2;
                                state_q <= LD_REQ;
                            end
                            2'd2: begin
                                w_mid_q <= mem_rdata;
                                widx_q  <= 2'd3;
                                state_q <= LD_REQ;
                            end
                            default: begin
                                idx_q   <= idx_q + 1'b1;
                                cnt_q   <= cnt_q - 1'b1;
                                ptr_q   <= ptr_q + MEM_AW'(DESC_WORDS);
                                state_q <= LD_CHECK;
                            end
                        endcase
                    end
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/afm_cam_store.sv
module afm_cam_store
    import afm_pkg::*;
#(
    parameter int unsigned NUM_ENT = 16,
    parameter int unsigned IDX_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ent_we,
    input  logic [IDX_W-1:0]    ent_idx,
    input  logic [DA_W-1:0]     ent_data,
    input  logic                mask_we,
    input  logic [NUM_ENT-1:0]  mask_data,
    output logic [NUM_ENT-1:0]  mask_q,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [DA_W-1:0]     rd_entry,
    input  logic [DA_W-1:0]     da,
    output logic                hit_any
);

    logic [DA_W-1:0]    entry_q [NUM_ENT];
    logic [NUM_ENT-1:0] hit_vec;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (ent_we && (ent_idx == IDX_W'(g))) begin
                entry_q[g] <= ent_data;
            end
        end
        assign hit_vec[g] = mask_q[g] && (entry_q[g] == da);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_data;
        end
    end

    assign hit_any  = |hit_vec;
    assign rd_entry = entry_q[rd_idx];

endmodule

// File: rtl/afm_decide.sv
module afm_decide
    import afm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            da_valid,
    input  logic [DA_W-1:0] da,
    input  mode_t           mode,
    input  logic            hit_any,
    output logic            res_valid,
    output verdict_t        verdict
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            verdict   <= '0;
        end else begin
            res_valid <= da_valid;
            verdict   <= da_valid ? judge(mode, da, hit_any) : '0;
        end
    end

endmodule

// File: rtl/addr_match_filter.sv
module addr_match_filter
    import afm_pkg::*;
#(
    parameter int unsigned NUM_ENT = 16,
    parameter int unsigned MEM_AW  = 16,
    parameter int unsigned CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr_en,
    input  logic [3:0]         host_addr,
    input  logic [15:0]        host_wdata,
    output logic [15:0]        host_rdata,
    output logic               mem_rd_en,
    output logic [MEM_AW-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [15:0]        mem_rdata,
    input  logic               da_valid,
    input  logic [47:0]        da,
    output logic               res_valid,
    output logic               res_accept,
    output logic               res_mcast,
    output logic               res_bcast
);

    localparam int unsigned IDX_W = $clog2(NUM_ENT);

    mode_t               mode_q;
    logic                rmode_q;
    logic                done_q;
    logic [IDX_W-1:0]    esel_q;

    logic                ld_busy;
    logic                ld_done;
    logic [MEM_AW-1:0]   dptr;
    logic [CNT_W-1:0]    dcnt;
    logic                ent_we;
    logic [IDX_W-1:0]    ent_idx;
    logic [DA_W-1:0]     ent_data;
    logic                mask_we;
    logic [WORD_W-1:0]   mask_word;
    logic [NUM_ENT-1:0]  mask_q;
    logic [DA_W-1:0]     rd_entry;
    logic                hit_any;
    verdict_t            verdict;

    logic wr_cmd, wr_mode, wr_stat, wr_dptr, wr_dcnt, wr_esel;

    assign wr_cmd  = host_wr_en && (host_addr == RA_CMD);
    assign wr_mode = host_wr_en && (host_addr == RA_MODE);
    assign wr_stat = host_wr_en && (host_addr == RA_STAT);
    assign wr_dptr = host_wr_en && (host_addr == RA_DPTR);
    assign wr_dcnt = host_wr_en && (host_addr == RA_DCNT);
    assign wr_esel = host_wr_en && (host_addr == RA_ESEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            rmode_q <= 1'b1;
            done_q  <= 1'b0;
            esel_q  <= '0;
        end else begin
            if (wr_mode) mode_q  <= mode_t'(host_wdata[2:0]);
            if (wr_cmd)  rmode_q <= host_wdata[CMD_RMODE_BIT];
            if (wr_esel) esel_q  <= host_wdata[IDX_W-1:0];
            if (ld_done) begin
                done_q <= 1'b1;
            end else if (wr_stat && host_wdata[STAT_DONE_BIT]) begin
                done_q <= 1'b0;
            end
        end
    end

    afm_cam_loader #(
        .MEM_AW (MEM_AW),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) u_loader (
        .clk        (clk),
        .rst        (rst),
        .start      (wr_cmd && host_wdata[CMD_LOAD_BIT]),
        .ptr_we     (wr_dptr),
        .cnt_we     (wr_dcnt),
        .wdata      (host_wdata),
        .busy       (ld_busy),
        .done_pulse (ld_done),
        .ptr_q      (dptr),
        .cnt_q      (dcnt),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .ent_we     (ent_we),
        .ent_idx    (ent_idx),
        .ent_data   (ent_data),
        .mask_we    (mask_we),
        .mask_data  (mask_word)
    );

    afm_cam_store #(
        .NUM_ENT (NUM_ENT),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .ent_we    (ent_we),
        .ent_idx   (ent_idx),
        .ent_data  (ent_data),
        .mask_we   (mask_we),
        .mask_data (mask_word[NUM_ENT-1:0]),
        .mask_q    (mask_q),
        .rd_idx    (esel_q),
        .rd_entry  (rd_entry),
        .da        (da),
        .hit_any   (hit_any)
    );

    afm_decide u_decide (
        .clk       (clk),
        .rst       (rst),
        .da_valid  (da_valid),
        .da        (da),
        .mode      (mode_q),
        .hit_any   (hit_any),
        .res_valid (res_valid),
        .verdict   (verdict)
    );

    assign res_accept = verdict.accept;
    assign res_mcast  = verdict.mcast;
    assign res_bcast  = verdict.bcast;

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            RA_CMD: begin
                host_rdata[CMD_LOAD_BIT]  = ld_busy;
                host_rdata[CMD_RMODE_BIT] = rmode_q;
            end
            RA_MODE:  host_rdata[2:0] = mode_q;
            RA_STAT:  host_rdata[STAT_DONE_BIT] = done_q;
            RA_DPTR:  host_rdata = 16'(dptr);
            RA_DCNT:  host_rdata = 16'(dcnt);
            RA_ESEL:  host_rdata = 16'(esel_q);
            RA_RB0:   if (rmode_q) host_rdata = rd_entry[15:0];
            RA_RB1:   if (rmode_q) host_rdata = rd_entry[31:16];
            RA_RB2:   if (rmode_q) host_rdata = rd_entry[47:32];
            RA_EMASK: host_rdata = 16'(mask_q);
            default:  host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/afm_checker.sv
module afm_checker
    import afm_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        da_valid,
    input logic [47:0] da,
    input mode_t       mode,
    input logic        res_valid,
    input logic        res_accept,
    input logic        res_mcast,
    input logic        res_bcast,
    input logic        rmode,
    input logic [3:0]  host_addr,
    input logic [15:0] host_rdata,
    input logic        mem_rd_en,
    input logic        busy,
    input logic        done
);

    AST_RES_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (rst)
        da_valid |=> res_valid);  // R5
    AST_RES_ONLY_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        !da_valid |=> !res_valid);  // R5
    AST_PROMISC_UNICAST: assert property (@(posedge clk) disable iff (rst)
        (da_valid && mode.prom && !da[0]) |=> (res_accept && !res_mcast && !res_bcast));  // R1
    AST_ALLMC_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (da_valid && !mode.prom && mode.allmc && da[0]) |=> (res_accept && res_mcast && !res_bcast));  // R2
    AST_FLAG_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (res_mcast || res_bcast) |-> res_accept);  // R2
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(res_mcast && res_bcast));  // R3
    AST_READBACK_GATED: assert property (@(posedge clk) disable iff (rst)
        (!rmode && (host_addr == RA_RB0 || host_addr == RA_RB1 || host_addr == RA_RB2))
            |-> (host_rdata == 16'h0000));  // R10
    AST_MEM_ONLY_LOADING: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> busy);  // R11
    AST_DONE_AT_FINISH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);  // R8

endmodule

bind addr_match_filter afm_checker u_afm_checker (
    .clk        (clk),
    .rst        (rst),
    .da_valid   (da_valid),
    .da         (da),
    .mode       (mode_q),
    .res_valid  (res_valid),
    .res_accept (res_accept),
    .res_mcast  (res_mcast),
    .res_bcast  (res_bcast),
    .rmode      (rmode_q),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .mem_rd_en  (mem_rd_en),
    .busy       (ld_busy),
    .done       (done_q)
);

// File: tb/addr_match_filter_test.sv
module addr_match_filter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        res_valid, res_accept, res_mcast, res_bcast;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    logic [15:0] mem [0:255];

    logic [2:0] exp_q [$];
    string      tag_q [$];
    logic       prev_dav = 1'b0;

    localparam logic [47:0] ENT_A = 48'h665544332210;
    localparam logic [47:0] ENT_B = 48'h0A0B0C0D0E02;
    localparam logic [47:0] ENT_C = 48'h123456789A0C;
    localparam logic [47:0] ENT_D = 48'hABCDEF012346;
    localparam logic [47:0] BCAST = 48'hFFFFFFFFFFFF;

    always #2 clk = ~clk;  // 250 MHz

    addr_match_filter uut (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .da_valid(da_valid), .da(da),
        .res_valid(res_valid), .res_accept(res_accept),
        .res_mcast(res_mcast), .res_bcast(res_bcast)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        mem_rvalid <= mem_rd_en;
        mem_rdata  <= mem[mem_addr[7:0]];
        prev_dav   <= da_valid;
    end

    task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops expected verdicts as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_dav) begin
                checks++;
                if (!res_valid) begin
                    fails++;
                    $display("FAIL R5: actual res_valid 0 expected 1");
                end else if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R5: actual unexpected verdict expected none");
                end else begin
                    logic [2:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ({res_accept, res_mcast, res_bcast} !== e) begin
                        fails++;
                        $display("FAIL %s: actual %b expected %b", t,
                                 {res_accept, res_mcast, res_bcast}, e);
                    end
                end
            end else if (res_valid) begin
                checks++;
                fails++;
                $display("FAIL R5: actual res_valid 1 expected 0");
            end
        end
    end

    task automatic send_da(logic [47:0] a, logic [2:0] exp, string req);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        da_valid = 1'b1;
        da = a;
        @(negedge clk);
        da_valid = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_load();
        logic [15:0] v;
        for (int i = 0; i < 200; i++) begin
            rd(4'd0, v);
            if (!v[9]) break;
        end
    endtask

    task automatic put_entry(int base, logic [47:0] e);
        mem[base + 1] = e[15:0];
        mem[base + 2] = e[31:16];
        mem[base + 3] = e[47:32];
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        put_entry(16'h10, ENT_A);
        put_entry(16'h14, ENT_B);
        put_entry(16'h18, ENT_C);
        mem[16'h1C] = 16'h0005;
        put_entry(16'h40, ENT_D);
        mem[16'h44] = 16'h0001;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state
        rd(4'd0, v); chk("R10 reset cmd", 48'(v), 48'h0080);
        rd(4'd2, v); chk("R8 reset stat", 48'(v), 48'h0);
        rd(4'd9, v); chk("R7 reset mask", 48'(v), 48'h0);
        chk("R5 reset res_valid", 48'(res_valid), 48'h0);

        // first load: three descriptors at 0x10
        wr(4'd3, 16'h0010);
        wr(4'd4, 16'd3);
        wr(4'd0, 16'h0280);
        wait_load();
        rd(4'd0, v); chk("R8 load bit cleared", 48'(v), 48'h0080);
        rd(4'd2, v); chk("R8 done set", 48'(v), 48'h1000);
        rd(4'd4, v); chk("R6 count zero", 48'(v), 48'h0);
        rd(4'd3, v); chk("R6 pointer advanced", 48'(v), 48'h001C);
        rd(4'd9, v); chk("R7 mask", 48'(v), 48'h0005);
        wr(4'd5, 16'h0001);
        rd(4'd6, v); chk("R6 entry1 w1", 48'(v), 48'(ENT_B[15:0]));
        rd(4'd7, v); chk("R6 entry1 w2", 48'(v), 48'(ENT_B[31:16]));
        rd(4'd8, v); chk("R6 entry1 w3", 48'(v), 48'(ENT_B[47:32]));
        wr(4'd5, 16'h0012);
        rd(4'd6, v); chk("R10 index low bits", 48'(v), 48'(ENT_C[15:0]));
        wr(4'd0, 16'h0000);
        rd(4'd6, v); chk("R10 gated rb0", 48'(v), 48'h0);
        rd(4'd8, v); chk("R10 gated rb2", 48'(v), 48'h0);
        wr(4'd2, 16'h1000);
        rd(4'd2, v); chk("R8 done w1c", 48'(v), 48'h0);

        // exact match mode
        send_da(ENT_A, 3'b100, "R4 enabled A");
        send_da(ENT_B, 3'b000, "R4 disabled B");
        send_da(ENT_C, 3'b100, "R4 enabled C");
        send_da(48'h111111111110, 3'b000, "R4 no match");
        send_da(BCAST, 3'b000, "R3 bcast mode off");

        wr(4'd1, 16'h0001);
        send_da(48'h222222222220, 3'b100, "R1 promisc unicast");
        send_da(48'h222222222221, 3'b000, "R1 promisc multicast");

        wr(4'd1, 16'h0002);
        send_da(48'h333333333331, 3'b110, "R2 all multicast");
        wr(4'd1, 16'h0006);
        send_da(BCAST, 3'b110, "R2 priority over broadcast");

        wr(4'd1, 16'h0004);
        send_da(BCAST, 3'b101, "R3 broadcast");
        send_da(48'h444444444441, 3'b000, "R3 other multicast");

        wr(4'd1, 16'h0007);
        send_da(48'h555555555554, 3'b100, "R1 promisc first");

        // second load: one descriptor, index restarts at 0
        wr(4'd1, 16'h0000);
        wr(4'd3, 16'h0040);
        wr(4'd4, 16'd1);
        wr(4'd0, 16'h0200);
        wait_load();
        rd(4'd3, v); chk("R6 pointer second load", 48'(v), 48'h0044);
        rd(4'd9, v); chk("R7 mask second load", 48'(v), 48'h0001);
        send_da(ENT_D, 3'b100, "R9 new entry 0");
        send_da(ENT_A, 3'b000, "R9 entry 0 overwritten");
        send_da(ENT_C, 3'b000, "R7 mask disables C");
        wr(4'd0, 16'h0080);
        wr(4'd5, 16'h0000);
        rd(4'd8, v); chk("R9 entry0 w3", 48'(v), 48'(ENT_D[47:32]));
        wr(4'd5, 16'h0001);
        rd(4'd6, v); chk("R9 entry1 kept", 48'(v), 48'(ENT_B[15:0]));

        repeat (3) @(negedge clk);
        chk("R5 all verdicts seen", 48'(exp_q.size()), 48'h0);
        done_flag = 1;
        finish_run();
    end

endmodule